// File: doc/BRIEF.md
# Flash Program Suspend/Resume Command Controller

This block is the command interpreter of a NOR-flash-style device model. Its job is to start, pause and resume an embedded word-program operation. The host drives bus write cycles, each one an address and a data word. The block decodes these against a small command set: the unlocked program sequence, suspend, resume, identifier mode and reset. Programming is modelled as a counter of fixed length. While that counter runs, `busy` is high. A status read returns a data-polling bit and a toggle bit, in the same way the device reports a normal program.

A suspended program can be interrupted a second time by an identifier-mode session. Leaving that session lands the block back in the suspended state, not in read mode. A digital high-voltage flag, `hv_boost`, puts the block into short-command mode. In that mode the program command needs no unlock cycles, and a write-buffer load is available. If a buffer load is aborted, only the complete three-cycle reset sequence clears the abort.

Top module: `flash_susp_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `shortcmd`, `rd_valid` and `progress` are 0. A read at any address returns FFFFh.
- R2: A program starts after three unlock writes followed by one address/data write. The unlock writes are AAh at low address bits 555h, 55h at 2AAh, and A0h at 555h. Commands use `wr_data[7:0]`, and unlock addresses compare `wr_addr[10:0]`. `busy` rises one cycle after the address/data write and stays high for exactly PROG_CYCLES programming cycles. Once it falls, a read of the programmed address returns the written word, and a read of any other address returns FFFFh.
- R3: Writing B0h at any address while programming suspends the program. `busy` falls in the next cycle, and `progress` holds its value for as long as the block stays suspended.
- R4: Writing 30h at any address while suspended resumes the program. `busy` rises in the next cycle, and the suspended time does not add to the PROG_CYCLES programming cycles.
- R5: A 30h write is ignored while programming or idle, and a B0h write is ignored while idle or suspended.
- R6: Suspend can be issued again after a resume, and it takes effect in the same way.
- R7: A read issued one cycle earlier returns its value on `rd_data` with `rd_valid` high. In the programming, suspended and abort states, a read returns status: bit 7 holds the complement of bit 7 of the target word, bit 6 holds the toggle bit, bit 1 is set only in abort, and all other bits are 0. The toggle bit inverts after each read made while programming. It holds steady while suspended.
- R8: While suspended, the unlock sequence ending in 90h at 555h enters identifier mode. In identifier mode, reads at `rd_addr[1:0]`=0 return MFR_ID and reads at 1 return DEV_ID, whatever the address range. Other offsets return 0. All writes except F0h are ignored. F0h returns the block to the suspended state.
- R9: `shortcmd` is high one cycle after `hv_boost` is high. In short-command mode, a single A0h write at any address, followed by an address/data write, starts a program.
- R10: After `hv_boost` falls, `shortcmd` stays high until the block is idle in read mode. It then clears one cycle later.
- R11: In short-command mode, a buffer load is the sequence 25h, then a word, then 29h, and it starts programming that word. If the third write is anything other than 29h, the block enters abort, with `busy` low and status bit 1 set.
- R12: In abort, a single F0h write is ignored. Only AAh at 555h, then 55h at 2AAh, then F0h at 555h returns the block to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_boost | input | 1 | High-voltage accelerate flag |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data; commands in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Array word, status word or identifier code |
| busy | output | 1 | High while the program counter runs |
| shortcmd | output | 1 | Short-command mode active |
| progress | output | log2(PROG_CYCLES) | Programming progress counter |

## Verification
The properties assume that the host issues at most one write per cycle. They also assume that no command write arrives in the same cycle in which the counter reaches its final value. In that cycle, completion takes precedence and the write would be lost. The stimulus respects this by issuing suspend and resume well inside the programming window, and by waiting for `busy` to fall before starting the next sequence. `hv_boost` is changed only between bus writes, so the mode change never coincides with a command decode.

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl #(
  parameter int          AW          = 20,
  parameter int          PROG_CYCLES = 64,
  parameter logic [15:0] MFR_ID      = 16'h0001,
  parameter logic [15:0] DEV_ID      = 16'h227E,
  localparam int         CW          = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_boost,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic          busy,
  output logic          shortcmd,
  output logic [CW-1:0] progress
);

  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  typedef enum logic [3:0] {
    S_READ, S_PADDR, S_PROG, S_SUSP, S_ID, S_ID_S, S_BLOAD, S_BCONF, S_ABORT
  } st_t;

  st_t           st, nst;
  logic [1:0]    ucnt, nucnt;
  logic          cap, clr;
  logic [AW-1:0] tgt_addr, mem_addr;
  logic [15:0]   tgt_data, mem_data;
  logic          tgl;
  logic [15:0]   stat_w, rd_mux;

  logic [7:0] cmd;
  logic       a555, a2aa, u1, u2, u3, done;

  assign cmd  = wr_data[7:0];
  assign a555 = (wr_addr[10:0] == 11'h555);
  assign a2aa = (wr_addr[10:0] == 11'h2AA);
  assign u1   = (ucnt == 2'd0) && (cmd == 8'hAA) && a555;
  assign u2   = (ucnt == 2'd1) && (cmd == 8'h55) && a2aa;
  assign u3   = (ucnt == 2'd2) && a555;
  assign done = (st == S_PROG) && (progress == LAST);

  always_comb begin
    nst   = st;
    nucnt = ucnt;
    cap   = 1'b0;
    clr   = 1'b0;
    case (st)
      S_READ:
        if (wr_en) begin
          nucnt = 2'd0;
          if (shortcmd) begin
            if (cmd == 8'hA0)      nst = S_PADDR;
            else if (cmd == 8'h25) nst = S_BLOAD;
          end else if (u1)                 nucnt = 2'd1;
          else if (u2)                     nucnt = 2'd2;
          else if (u3 && cmd == 8'hA0)     nst = S_PADDR;
          else if (u3 && cmd == 8'h90)     nst = S_ID;
        end
      S_PADDR:
        if (wr_en) begin
          nst = S_PROG;
          cap = 1'b1;
          clr = 1'b1;
        end
      S_PROG:
        if (done)                          nst = S_READ;
        else if (wr_en && cmd == 8'hB0)    nst = S_SUSP;
      S_SUSP:
        if (wr_en) begin
          nucnt = 2'd0;
          if (cmd == 8'h30)                nst = S_PROG;
          else if (u1)                     nucnt = 2'd1;
          else if (u2)                     nucnt = 2'd2;
          else if (u3 && cmd == 8'h90)     nst = S_ID_S;
        end
      S_ID:
        if (wr_en && cmd == 8'hF0)         nst = S_READ;
      S_ID_S:
        if (wr_en && cmd == 8'hF0)         nst = S_SUSP;
      S_BLOAD:
        if (wr_en) begin
          nst = S_BCONF;
          cap = 1'b1;
        end
      S_BCONF:
        if (wr_en) begin
          if (cmd == 8'h29) begin
            nst = S_PROG;
            clr = 1'b1;
          end else begin
            nst = S_ABORT;
          end
        end
      S_ABORT:
        if (wr_en) begin
          nucnt = 2'd0;
          if (u1)                          nucnt = 2'd1;
          else if (u2)                     nucnt = 2'd2;
          else if (u3 && cmd == 8'hF0)     nst = S_READ;
        end
      default: nst = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_READ;
      ucnt     <= 2'd0;
      progress <= '0;
      tgt_addr <= '0;
      tgt_data <= 16'hFFFF;
      mem_addr <= '0;
      mem_data <= 16'hFFFF;
      shortcmd <= 1'b0;
    end else begin
      st       <= nst;
      ucnt     <= nucnt;
      shortcmd <= hv_boost | (shortcmd & (st != S_READ));
      if (cap) begin
        tgt_addr <= wr_addr;
        tgt_data <= wr_data;
      end
      if (clr)
        progress <= '0;
      else if (st == S_PROG && !done)
        progress <= progress + 1'b1;
      if (done) begin
        mem_addr <= tgt_addr;
        mem_data <= tgt_data;
      end
    end
  end

  assign stat_w = {8'h00, ~tgt_data[7], tgl, 4'h0, (st == S_ABORT), 1'b0};

  always_comb begin
    case (st)
      S_PROG, S_SUSP, S_ABORT: rd_mux = stat_w;
      S_ID, S_ID_S:
        case (rd_addr[1:0])
          2'd0:    rd_mux = MFR_ID;
          2'd1:    rd_mux = DEV_ID;
          default: rd_mux = 16'h0000;
        endcase
      default: rd_mux = (rd_addr == mem_addr) ? mem_data : 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 16'h0000;
      tgl      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (rd_en && st == S_PROG) tgl <= ~tgl;
    end
  end

  assign busy = (st == S_PROG);

endmodule

// File: rtl/flash_susp_ctrl_chk.sv
module flash_susp_ctrl_chk #(
  parameter int PROG_CYCLES = 64,
  localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hv_boost,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic          rd_valid,
  input logic          busy,
  input logic          shortcmd,
  input logic [CW-1:0] progress,
  input logic          in_susp,
  input logic          in_abort,
  input logic [1:0]    ustage
);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !shortcmd && !rd_valid && progress == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && progress != LAST |=> progress == $past(progress) + 1'b1);

  p_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && progress == LAST |=> !busy);

  p_suspend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && progress != LAST && wr_en && wr_data[7:0] == 8'hB0 |=> !busy);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || $stable(progress)));

  p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_susp && wr_en && wr_data[7:0] == 8'h30 |=> busy);

  p_resuspend_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_susp && wr_en && wr_data[7:0] == 8'hB0 |=> !busy);

  p_boost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hv_boost |=> shortcmd);

  p_abort_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_abort && wr_en && wr_data[7:0] == 8'hF0 && ustage == 2'd0 |=> in_abort);
endmodule

bind flash_susp_ctrl flash_susp_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hv_boost (hv_boost),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_valid (rd_valid),
  .busy     (busy),
  .shortcmd (shortcmd),
  .progress (progress),
  .in_susp  (st == S_SUSP),
  .in_abort (st == S_ABORT),
  .ustage   (ucnt)
);

// File: tb/sim_flash_susp_ctrl.sv
module sim_flash_susp_ctrl;
  localparam int AW = 20;
  localparam int PC = 64;
  localparam int CW = $clog2(PC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hv_boost = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid, busy, shortcmd;
  logic [15:0]   rd_data;
  logic [CW-1:0] progress;

  flash_susp_ctrl #(.AW(AW), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .hv_boost(hv_boost), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .shortcmd(shortcmd), .progress(progress));

  always #4 clk = ~clk;

  int vectors = 0, miss = 0, busy_cyc = 0;
  bit finished = 1'b0;
  bit btgl = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) if (busy) busy_cyc++;

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miss++;
        $display("FAIL R7: unexpected read data %h, expected none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (rd_data !== e) begin
          miss++;
          $display("FAIL %s: read got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock(input logic [AW-1:0] bank, input logic [7:0] c3);
    wr(bank | 20'h00555, 16'h00AA);
    wr(bank | 20'h002AA, 16'h0055);
    wr(bank | 20'h00555, {8'h00, c3});
  endtask

  function automatic logic [15:0] stat(input bit b7, input bit ab);
    return {8'h00, ~b7, btgl, 4'h0, ab, 1'b0};
  endfunction

  task automatic rd_prog(input bit b7, input string tag);
    rd(20'h0, stat(b7, 1'b0), tag);
    btgl = ~btgl;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miss++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(busy, 0, "R1 busy in reset");
    chk(shortcmd, 0, "R1 shortcmd in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(progress, 0, "R1 progress after reset");
    chk(rd_valid, 0, "R1 rd_valid after reset");
    rd(20'h00000, 16'hFFFF, "R1 erased read");

    busy_cyc = 0;
    unlock(20'h00000, 8'hA0);
    wr(20'h01234, 16'h00C5);
    chk(busy, 1, "R2 busy after program word");
    rd_prog(1'b1, "R7 status first read");
    rd_prog(1'b1, "R7 status toggled");
    rd_prog(1'b1, "R7 status toggled back");
    wr(20'h00000, 16'h0030);
    chk(busy, 1, "R5 resume ignored while programming");

    wr(20'h0ABCD, 16'h00B0);
    chk(busy, 0, "R3 suspend drops busy");
    begin
      logic [CW-1:0] p;
      p = progress;
      repeat (10) @(negedge clk);
      chk(progress, p, "R3 progress frozen");
    end
    rd(20'h0, stat(1'b1, 1'b0), "R7 toggle holds in suspend");
    rd(20'h0, stat(1'b1, 1'b0), "R7 toggle holds in suspend again");
    wr(20'h00000, 16'h00B0);
    chk(busy, 0, "R5 suspend ignored while suspended");
    rd(20'h0, stat(1'b1, 1'b0), "R5 still suspended");

    unlock(20'h80000, 8'h90);
    rd(20'h01234, 16'h0001, "R8 maker code in suspended range");
    rd(20'h01235, 16'h227E, "R8 device code");
    rd(20'h01236, 16'h0000, "R8 other offset");
    wr(20'h00000, 16'h0030);
    chk(busy, 0, "R8 resume ignored in identifier mode");
    wr(20'h00000, 16'h00F0);
    chk(busy, 0, "R8 exit keeps suspended");
    rd(20'h0, stat(1'b1, 1'b0), "R8 back to suspend status");

    wr(20'h05555, 16'h0030);
    chk(busy, 1, "R4 resume raises busy");
    wr(20'h00000, 16'h0030);
    chk(busy, 1, "R5 extra resume ignored");
    wr(20'h00000, 16'h00B0);
    chk(busy, 0, "R6 second suspend");
    repeat (5) @(negedge clk);
    wr(20'h00000, 16'h0030);
    chk(busy, 1, "R6 second resume");
    wait_idle();
    chk(busy_cyc, PC, "R4 total programming cycles");
    chk(progress, PC - 1, "R2 progress at end");
    rd(20'h01234, 16'h00C5, "R2 programmed word");
    rd(20'h01235, 16'hFFFF, "R2 other address erased");

    wr(20'h00000, 16'h0030);
    chk(busy, 0, "R5 resume ignored when idle");
    wr(20'h00000, 16'h00B0);
    chk(busy, 0, "R5 suspend ignored when idle");
    rd(20'h01234, 16'h00C5, "R5 idle reads array");

    @(negedge clk); hv_boost = 1'b1;
    @(negedge clk);
    chk(shortcmd, 1, "R9 shortcmd follows boost");
    wr(20'h03333, 16'h00A0);
    wr(20'h00200, 16'h0011);
    chk(busy, 1, "R9 short program starts");
    rd_prog(1'b0, "R7 status poll bit low target");
    hv_boost = 1'b0;
    repeat (3) @(negedge clk);
    chk(shortcmd, 1, "R10 shortcmd held while busy");
    wait_idle();
    repeat (2) @(negedge clk);
    chk(shortcmd, 0, "R10 shortcmd clears when idle");
    rd(20'h00200, 16'h0011, "R9 short program word");

    @(negedge clk); hv_boost = 1'b1;
    @(negedge clk);
    wr(20'h00000, 16'h0025);
    wr(20'h00400, 16'h0080);
    wr(20'h00000, 16'h0000);
    chk(busy, 0, "R11 abort busy low");
    rd(20'h0, stat(1'b1, 1'b1), "R11 abort flag");
    wr(20'h00000, 16'h00F0);
    rd(20'h0, stat(1'b1, 1'b1), "R12 single reset ignored");
    unlock(20'h00000, 8'hF0);
    rd(20'h00400, 16'hFFFF, "R12 full reset returns to read");

    wr(20'h00000, 16'h0025);
    wr(20'h00600, 16'h1234);
    wr(20'h00000, 16'h0029);
    chk(busy, 1, "R11 confirm starts program");
    wait_idle();
    rd(20'h00600, 16'h1234, "R11 buffer word programmed");
    hv_boost = 1'b0;

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      miss += exp_q.size();
      $display("FAIL R7: %0d reads got no data expected 0 pending", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule